// File: doc/BRIEF.md
# SDRAM Read Burst Truncation Sequencer

This block sits on the controller side of an SDRAM port. It takes one read request at a time and issues a READ to a row that is already open. When the requester wants fewer words than the burst would deliver, it stops the burst early with a BURST TERMINATE command. Each request carries a bank, a start column, a word count, a burst mode and a CAS latency choice of 2 or 3. The sequencer drives the command bus and the data mask. It samples the data bus in the cycles where wanted words arrive and presents them as a valid/data/last stream.

The terminate command has to go out CAS latency minus one cycles before the edge where the last wanted word is valid. Counted from the READ cycle, this places it exactly N cycles after the READ for N wanted words, whatever the latency. A full-page burst can always be cut. A fixed-length burst can be cut only when auto precharge is off. A request to cut a fixed burst that has auto precharge set is flagged as an error, and that burst runs to its full length.

Top module: `rd_trunc_seq`

## Requirements
- R1: A request is accepted in a cycle where `req_valid_i` and `req_ready_o` are both high. In the next cycle `cmd_o` shows READ (3'b101), `cmd_bank_o`/`cmd_col_o` carry the request's bank and column, and `cmd_ap_o` is 1 only for mode 2'b01 (fixed length with auto precharge).
- R2: Wanted word i is sampled from `dq_i` in the cycle that is CL+i cycles after the READ cycle. With CL 2 when `req_cl3_i`=0 and CL 3 when it is 1, the first word appears on `rd_data_o` with `rd_valid_o` high CL+1 cycles after the READ cycle. After that, one word is presented per cycle.
- R3: When a burst is truncated to N words, BURST TERMINATE (3'b110) is issued N cycles after the READ cycle. This is CL-1 cycles before the cycle in which the last wanted word is on `dq_i`.
- R4: In full-page mode (`req_mode_i[1]`=1), the burst is always truncated. Exactly N = `req_len_i`+1 words are delivered.
- R5: In fixed-length mode without auto precharge (2'b00), when N is less than BURST_LEN, the burst is truncated and N words are delivered.
- R6: In a fixed-length mode where N is at least BURST_LEN, no terminate is issued and BURST_LEN words are delivered.
- R7: In mode 2'b01 with N below BURST_LEN, `req_err_o` pulses high in the READ cycle and no terminate is issued. BURST_LEN words are delivered, and a terminate is never issued while auto precharge is set.
- R8: In every cycle other than the READ and terminate cycles, `cmd_o` shows NOP (3'b111).
- R9: `dqm_o` is low while `busy_o` is high and high while the block is idle.
- R10: `busy_o` rises in the READ cycle and falls in the cycle the last word is presented. `req_ready_o` is its inverse. Requests driven while busy are ignored, and exactly one READ is issued per accepted request.
- R11: `rd_last_o` is high with the final delivered word only, and `rd_valid_o` stays low after it until a new READ.
- R12: While reset is asserted and right after it is released, `cmd_o` is NOP. At that time `busy_o` and `rd_valid_o` are low, and `dqm_o` and `req_ready_o` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Read request present |
| req_ready_o | output | 1 | Sequencer can accept a request |
| req_bank_i | input | BANK_W | Bank of the open row |
| req_col_i | input | COL_W | Start column |
| req_len_i | input | $clog2(PAGE_LEN) | Wanted words minus one |
| req_mode_i | input | 2 | 00 fixed, 01 fixed with auto precharge, 1x full page |
| req_cl3_i | input | 1 | CAS latency 3 when high, 2 when low |
| req_err_o | output | 1 | Illegal truncation request, burst runs to full length |
| busy_o | output | 1 | Read in progress |
| cmd_o | output | 3 | Command {ras_n, cas_n, we_n} |
| cmd_bank_o | output | BANK_W | Bank address with the command |
| cmd_col_o | output | COL_W | Column address with the command |
| cmd_ap_o | output | 1 | Auto precharge address bit |
| dqm_o | output | 1 | Data mask |
| dq_i | input | DATA_W | Read data from the device |
| rd_valid_o | output | 1 | Captured word valid |
| rd_data_o | output | DATA_W | Captured word |
| rd_last_o | output | 1 | Final wanted word |

## Verification
The bench builds the block with its defaults: a 16-bit data bus, 2 bank bits, 8 column bits, a fixed burst of 8 and a 256-word page. The short fixed burst lets small random counts land on all three fixed-mode outcomes: truncated, exactly full, and refused because of auto precharge. The 256-word page lets a full-page read of the longest possible length finish within a few hundred cycles. Because the CAS latency is chosen per request, both latencies are exercised in the same run. This includes the single-word case, where the terminate follows the READ directly.

// File: rtl/rd_trunc_pkg.sv
package rd_trunc_pkg;

  // command encoding {ras_n, cas_n, we_n}
  typedef enum logic [2:0] {
    CMD_NOP  = 3'b111,
    CMD_READ = 3'b101,
    CMD_BST  = 3'b110
  } cmd_e;

  localparam logic [1:0] MODE_FIXED    = 2'b00;
  localparam logic [1:0] MODE_FIXED_AP = 2'b01;

endpackage

// File: rtl/rd_trunc_plan.sv
module rd_trunc_plan #(
  parameter int BURST_LEN = 8,
  parameter int LEN_W     = 8,
  localparam int CNT_W    = LEN_W + 1
) (
  input  logic [LEN_W-1:0] len_m1_i,
  input  logic [1:0]       mode_i,
  output logic [CNT_W-1:0] words_o,
  output logic             trunc_o,
  output logic             err_o
);
  import rd_trunc_pkg::*;

  localparam logic [CNT_W-1:0] BL_C = CNT_W'(BURST_LEN);

  logic [CNT_W-1:0] len;
  assign len = CNT_W'(len_m1_i) + CNT_W'(1);

  always_comb begin
    words_o = len;
    trunc_o = 1'b1;
    err_o   = 1'b0;
    if (!mode_i[1]) begin
      if (len >= BL_C) begin
        words_o = BL_C;
        trunc_o = 1'b0;
      end else if (mode_i == MODE_FIXED_AP) begin
        // cut not allowed with auto precharge: full burst, flag it
        words_o = BL_C;
        trunc_o = 1'b0;
        err_o   = 1'b1;
      end
    end
  end

endmodule

// File: rtl/rd_trunc_cmd.sv
module rd_trunc_cmd #(
  parameter int BANK_W = 2,
  parameter int COL_W  = 8,
  parameter int CNT_W  = 9,
  parameter int T_W    = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic              ap_i,
  input  logic              cl3_i,
  input  logic [CNT_W-1:0]  words_i,
  input  logic              trunc_i,
  input  logic              err_i,
  output logic [2:0]        cmd_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [COL_W-1:0]  col_o,
  output logic              ap_o,
  output logic              busy_o,
  output logic              err_o,
  output logic [T_W-1:0]    t_o,
  output logic [CNT_W-1:0]  words_o,
  output logic              cl3_o,
  output logic              trunc_o
);
  import rd_trunc_pkg::*;

  cmd_e              cmd_q;
  logic              busy_q, err_q, ap_q, cl3_q, trunc_q;
  logic [BANK_W-1:0] bank_q;
  logic [COL_W-1:0]  col_q;
  logic [T_W-1:0]    t_q, end_t;
  logic [CNT_W-1:0]  words_q;
  logic              bst_next;

  // last capture cycle relative to READ: CL + words - 1
  assign end_t    = T_W'(words_q) + (cl3_q ? T_W'(2) : T_W'(1));
  assign bst_next = trunc_q && ((t_q + T_W'(1)) == T_W'(words_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q   <= CMD_NOP;
      busy_q  <= 1'b0;
      err_q   <= 1'b0;
      ap_q    <= 1'b0;
      cl3_q   <= 1'b0;
      trunc_q <= 1'b0;
      bank_q  <= '0;
      col_q   <= '0;
      t_q     <= '0;
      words_q <= '0;
    end else begin
      err_q <= 1'b0;
      if (!busy_q) begin
        cmd_q <= CMD_NOP;
        if (accept_i) begin
          cmd_q   <= CMD_READ;
          busy_q  <= 1'b1;
          err_q   <= err_i;
          ap_q    <= ap_i;
          cl3_q   <= cl3_i;
          trunc_q <= trunc_i;
          bank_q  <= bank_i;
          col_q   <= col_i;
          words_q <= words_i;
          t_q     <= '0;
        end
      end else begin
        t_q   <= t_q + T_W'(1);
        cmd_q <= bst_next ? CMD_BST : CMD_NOP;
        if (t_q == end_t) busy_q <= 1'b0;
      end
    end
  end

  assign cmd_o   = cmd_q;
  assign bank_o  = bank_q;
  assign col_o   = col_q;
  assign ap_o    = ap_q;
  assign busy_o  = busy_q;
  assign err_o   = err_q;
  assign t_o     = t_q;
  assign words_o = words_q;
  assign cl3_o   = cl3_q;
  assign trunc_o = trunc_q;

  p_read_after_accept_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |=> cmd_q == CMD_READ);

  p_cmd_legal_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_q inside {CMD_NOP, CMD_READ, CMD_BST});

  p_one_read_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && $past(busy_q) |-> cmd_q != CMD_READ);

  p_no_bst_with_ap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_q == CMD_BST |-> !ap_q);

endmodule

// File: rtl/rd_trunc_cap.sv
module rd_trunc_cap #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 9,
  parameter int T_W    = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [T_W-1:0]    t_i,
  input  logic [CNT_W-1:0]  words_i,
  input  logic              cl3_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              last_o
);
  logic [T_W-1:0] lo, hi;
  logic           hit;
  logic           valid_q, last_q;
  logic [DATA_W-1:0] data_q;

  assign lo  = cl3_i ? T_W'(3) : T_W'(2);
  assign hi  = lo + T_W'(words_i) - T_W'(1);
  assign hit = run_i && (t_i >= lo) && (t_i <= hi);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      last_q  <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= hit;
      last_q  <= hit && (t_i == hi);
      if (hit) data_q <= dq_i;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign last_o  = last_q;

  p_last_is_valid_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_q |-> valid_q);

  p_nothing_after_last_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_q |=> !valid_q);

endmodule

// File: rtl/rd_trunc_seq.sv
module rd_trunc_seq #(
  parameter int BANK_W    = 2,
  parameter int COL_W     = 8,
  parameter int DATA_W    = 16,
  parameter int BURST_LEN = 8,
  parameter int PAGE_LEN  = 256,
  localparam int LEN_W    = $clog2(PAGE_LEN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic [1:0]        req_mode_i,
  input  logic              req_cl3_i,
  output logic              req_err_o,
  output logic              busy_o,
  output logic [2:0]        cmd_o,
  output logic [BANK_W-1:0] cmd_bank_o,
  output logic [COL_W-1:0]  cmd_col_o,
  output logic              cmd_ap_o,
  output logic              dqm_o,
  input  logic [DATA_W-1:0] dq_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_last_o
);
  import rd_trunc_pkg::*;

  localparam int CNT_W = LEN_W + 1;
  localparam int T_W   = CNT_W + 1;

  logic             accept, busy, trunc_d, err_d, ap_d;
  logic [CNT_W-1:0] words_d, words_q;
  logic [T_W-1:0]   t_q;
  logic             cl3_q, trunc_q;

  assign accept = req_valid_i && !busy;
  assign ap_d   = (req_mode_i == MODE_FIXED_AP);

  rd_trunc_plan #(.BURST_LEN(BURST_LEN), .LEN_W(LEN_W)) u_plan (
    .len_m1_i (req_len_i),
    .mode_i   (req_mode_i),
    .words_o  (words_d),
    .trunc_o  (trunc_d),
    .err_o    (err_d)
  );

  rd_trunc_cmd #(.BANK_W(BANK_W), .COL_W(COL_W), .CNT_W(CNT_W), .T_W(T_W)) u_cmd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .bank_i   (req_bank_i),
    .col_i    (req_col_i),
    .ap_i     (ap_d),
    .cl3_i    (req_cl3_i),
    .words_i  (words_d),
    .trunc_i  (trunc_d),
    .err_i    (err_d),
    .cmd_o    (cmd_o),
    .bank_o   (cmd_bank_o),
    .col_o    (cmd_col_o),
    .ap_o     (cmd_ap_o),
    .busy_o   (busy),
    .err_o    (req_err_o),
    .t_o      (t_q),
    .words_o  (words_q),
    .cl3_o    (cl3_q),
    .trunc_o  (trunc_q)
  );

  rd_trunc_cap #(.DATA_W(DATA_W), .CNT_W(CNT_W), .T_W(T_W)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (busy),
    .t_i     (t_q),
    .words_i (words_q),
    .cl3_i   (cl3_q),
    .dq_i    (dq_i),
    .valid_o (rd_valid_o),
    .data_o  (rd_data_o),
    .last_o  (rd_last_o)
  );

  assign busy_o      = busy;
  assign req_ready_o = !busy;
  assign dqm_o       = !busy;

  // terminate leads the last presented word by CL cycles (CL-1 plus capture reg)
  p_bst_lead_cl2_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_last_o && trunc_q && !cl3_q |-> $past(cmd_o, 2) == CMD_BST);

  p_bst_lead_cl3_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_last_o && trunc_q && cl3_q |-> $past(cmd_o, 3) == CMD_BST);

  p_word_unmasked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(!dqm_o));

  p_err_on_ap_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_err_o |-> (cmd_o == CMD_READ) && cmd_ap_o);

endmodule

// File: tb/rd_trunc_seq_test.sv
module rd_trunc_seq_test;
  import rd_trunc_pkg::*;

  localparam int BL   = 8;
  localparam int PAGE = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [1:0]  req_bank_i = '0;
  logic [7:0]  req_col_i = '0;
  logic [7:0]  req_len_i = '0;
  logic [1:0]  req_mode_i = '0;
  logic        req_cl3_i = 1'b0;
  logic        req_err_o, busy_o, cmd_ap_o, dqm_o;
  logic [2:0]  cmd_o;
  logic [1:0]  cmd_bank_o;
  logic [7:0]  cmd_col_o;
  logic [15:0] dq_i = 16'hDEAD;
  logic        rd_valid_o, rd_last_o;
  logic [15:0] rd_data_o;

  always #2.5 clk = ~clk;

  rd_trunc_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_bank_i(req_bank_i), .req_col_i(req_col_i), .req_len_i(req_len_i),
    .req_mode_i(req_mode_i), .req_cl3_i(req_cl3_i), .req_err_o(req_err_o),
    .busy_o(busy_o), .cmd_o(cmd_o), .cmd_bank_o(cmd_bank_o), .cmd_col_o(cmd_col_o),
    .cmd_ap_o(cmd_ap_o), .dqm_o(dqm_o), .dq_i(dq_i), .rd_valid_o(rd_valid_o),
    .rd_data_o(rd_data_o), .rd_last_o(rd_last_o)
  );

  int checks = 0, errors = 0;
  int cyc = 0;
  int rd_cyc = 0, cur_cl = 2, dev_lim = 0, n_reads = 0, n_bst = 0, bst_cyc = -1;
  int n_words = 0, mism = 0, first_cyc = -1, last_idx = -1;
  bit dev_on = 0, last_seen = 0, after_last = 0, bad_cmd = 0, bad_dqm = 0, bad_busy = 0;
  bit cur_fixed = 0;
  logic [1:0] cur_bank = '0;
  logic [7:0] cur_col = '0;

  function automatic logic [15:0] pat(logic [1:0] b, logic [7:0] c, int i);
    return {1'b0, b, c[4:0], 8'(i)};
  endfunction

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  // device model and output monitor, away from the active edge
  always @(negedge clk) begin
    int i;
    cyc++;
    if (rst_n) begin
      if (cmd_o == CMD_READ) begin
        n_reads++;
        rd_cyc  = cyc;
        dev_on  = 1;
        dev_lim = cur_fixed ? BL - 1 : 1 << 20;
      end else if (cmd_o == CMD_BST) begin
        n_bst++;
        bst_cyc = cyc;
        if (cyc - rd_cyc - 1 < dev_lim) dev_lim = cyc - rd_cyc - 1;
      end else if (cmd_o != CMD_NOP) bad_cmd = 1;
      if (busy_o == dqm_o) bad_dqm = 1;
      if (rd_valid_o) begin
        if (last_seen) after_last = 1;
        if (n_words == 0) first_cyc = cyc;
        if (rd_data_o !== pat(cur_bank, cur_col, n_words)) mism++;
        if (rd_last_o) begin
          last_seen = 1;
          last_idx  = n_words;
          if (busy_o) bad_busy = 1;
        end
        n_words++;
      end
    end
    i = cyc - rd_cyc - cur_cl;
    if (dev_on && i > dev_lim) dev_on = 0;
    dq_i = (dev_on && i >= 0 && i <= dev_lim) ? pat(cur_bank, cur_col, i) : 16'hDEAD;
  end

  task automatic run_req(input logic [1:0] b, input logic [7:0] c, input int len_m1,
                         input logic [1:0] mode, input bit cl3, input bit poke);
    int n, exp_words;
    bit exp_trunc, exp_err, fixed;
    string rq;
    n = len_m1 + 1;
    fixed = !mode[1];
    exp_err = 0;
    if (!fixed) begin exp_words = n; exp_trunc = 1; rq = "R4"; end
    else if (n >= BL) begin exp_words = BL; exp_trunc = 0; rq = "R6"; end
    else if (mode == 2'b01) begin exp_words = BL; exp_trunc = 0; exp_err = 1; rq = "R7"; end
    else begin exp_words = n; exp_trunc = 1; rq = "R5"; end

    while (!req_ready_o) @(negedge clk);
    n_reads = 0; n_bst = 0; bst_cyc = -1; n_words = 0; mism = 0; first_cyc = -1;
    last_idx = -1; last_seen = 0; after_last = 0; bad_cmd = 0; bad_dqm = 0; bad_busy = 0;
    cur_bank = b; cur_col = c; cur_cl = cl3 ? 3 : 2; cur_fixed = fixed;
    req_valid_i = 1; req_bank_i = b; req_col_i = c; req_len_i = 8'(len_m1);
    req_mode_i = mode; req_cl3_i = cl3;
    @(negedge clk);
    req_valid_i = 0;
    chk(busy_o === 1'b1 && req_ready_o === 1'b0, "R10 busy after accept", busy_o, 1);
    chk(cmd_o == CMD_READ && cmd_bank_o == b && cmd_col_o == c && cmd_ap_o == (mode == 2'b01),
        "R1 READ command", cmd_o, CMD_READ);
    chk(req_err_o === exp_err, "R7 error flag", req_err_o, exp_err);
    if (poke) begin
      req_valid_i = 1; req_bank_i = ~b; req_col_i = ~c; req_len_i = 8'd0;
      repeat (2) @(negedge clk);
      req_valid_i = 0;
    end
    for (int k = 0; k < 400 && !last_seen; k++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(n_words == exp_words, {rq, " word count"}, n_words, exp_words);
    chk(mism == 0, "R2 data order", mism, 0);
    chk(first_cyc == rd_cyc + cur_cl + 1, "R2 first word latency", first_cyc - rd_cyc, cur_cl + 1);
    if (exp_trunc)
      chk(n_bst == 1 && bst_cyc == rd_cyc + n, "R3 terminate cycle", bst_cyc - rd_cyc, n);
    else
      chk(n_bst == 0, {rq, " no terminate"}, n_bst, 0);
    chk(last_idx == exp_words - 1 && !after_last, "R11 last flag", last_idx, exp_words - 1);
    chk(n_reads == 1 && !bad_busy, "R10 single READ and busy release", n_reads, 1);
    chk(!bad_cmd, "R8 NOP otherwise", bad_cmd, 0);
    chk(!bad_dqm, "R9 dqm tracks busy", bad_dqm, 0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    chk(cmd_o == CMD_NOP && !busy_o && !rd_valid_o && dqm_o && req_ready_o,
        "R12 state in reset", cmd_o, CMD_NOP);
    rst_n = 1;
    @(negedge clk);
    chk(cmd_o == CMD_NOP && !busy_o && !rd_valid_o && dqm_o && req_ready_o,
        "R12 state after reset", cmd_o, CMD_NOP);

    run_req(2'd1, 8'h10, 3,   2'b10, 0, 0);  // full page, 4 words, CL2
    run_req(2'd2, 8'h20, 3,   2'b10, 1, 0);  // full page, 4 words, CL3
    run_req(2'd0, 8'h03, 0,   2'b10, 0, 0);  // single word, CL2
    run_req(2'd3, 8'h07, 0,   2'b00, 1, 0);  // single word fixed, CL3
    run_req(2'd1, 8'h11, 2,   2'b00, 0, 1);  // fixed cut to 3, poked while busy
    run_req(2'd2, 8'h08, 7,   2'b00, 1, 0);  // exactly burst length
    run_req(2'd0, 8'h30, 20,  2'b01, 0, 0);  // above burst length with AP
    run_req(2'd3, 8'h1F, 1,   2'b01, 1, 0);  // illegal cut with AP
    run_req(2'd1, 8'hFF, 255, 2'b11, 1, 0);  // longest full page

    for (int k = 0; k < 40; k++) begin
      int len;
      len = ($urandom % 4 == 0) ? int'($urandom % PAGE) : int'($urandom % 12);
      run_req(2'($urandom), 8'($urandom), len, 2'($urandom), 1'($urandom), 1'($urandom));
    end
    finish_run();
  end

endmodule